// File: doc/BRIEF.md
# Relocatable On-Chip Memory Decoder

This block holds a small control register and decodes a 24-bit data-memory address bus into select strobes for three on-chip memories: an 8 kB SRAM, a 1 kB SRAM and a 256-byte peripheral buffer. A two-bit relocation code in the register picks one of three fixed placements for the two SRAMs. A single location bit picks one of two placements for the buffer. Every select and offset output is registered, so it appears one clock after the access is sampled.

Software changes the register through a protected write. A write only lands when the unlock strobe is high in the same cycle. An attempt to load the reserved relocation code leaves the placement unchanged, but the rest of the byte is still written. Bit 4 is fixed and always reads 1. The four low bits are plain stored control bits that are read back and decode nothing.

Top module: `reloc_mem_decoder`

## Requirements
- R1: After synchronous reset `ctrl_q` reads 8'h10 and every select and offset output is 0.
- R2: With relocation code `ctrl_q[7:6]`=00, the 1 kB SRAM decodes at 0x00DC00–0x00DFFF and the 8 kB SRAM at 0x00E000–0x00FFFF.
- R3: With code 01, the 8 kB SRAM decodes at 0x000000–0x001FFF and the 1 kB SRAM at 0x002000–0x0023FF.
- R4: With code 10, the 1 kB SRAM decodes at 0xFFDC00–0xFFDFFF and the 8 kB SRAM at 0xFFE000–0xFFFFFF.
- R5: An unlocked write whose bits [7:6] are 11 keeps the previous relocation code, and it still writes bit 5 and bits 3:0.
- R6: The buffer decodes at 0x00DB00–0x00DBFF when `ctrl_q[5]` is 0, and at 0xFFDB00–0xFFDBFF when it is 1.
- R7: A write with `unlock` low in the same cycle leaves `ctrl_q` unchanged.
- R8: `ctrl_q[4]` always reads 1, whatever value is written to it.
- R9: A select rises only for an access with `acc_valid` high whose address is in that memory's active window. Its offset is the address minus the window base. An offset is 0 whenever its select is low.
- R10: No more than one select is high in any cycle. The buffer select wins over both SRAM selects.
- R11: The outputs for an access show up one cycle after it is sampled. A write takes effect from the next cycle: an access in the same cycle as the write decodes with the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write request |
| unlock | input | 1 | Timed-access unlock strobe, must be high with wr_en |
| wr_data | input | 8 | Write data for the control register |
| ctrl_q | output | 8 | Control register read-back |
| acc_valid | input | 1 | Data-memory access is valid this cycle |
| acc_addr | input | 24 | Data-memory access address |
| sel_big | output | 1 | 8 kB SRAM select (registered) |
| off_big | output | 13 | Offset into the 8 kB SRAM |
| sel_small | output | 1 | 1 kB SRAM select (registered) |
| off_small | output | 10 | Offset into the 1 kB SRAM |
| sel_buf | output | 1 | 256-byte buffer select (registered) |
| off_buf | output | 8 | Offset into the buffer |

## Verification
The bench goes after the edges of every window under each relocation code and buffer location: the first and last byte inside each window and the byte just outside it. An off-by-one compare would miss or over-reach by one address. Protected writes are tried with `unlock` low, with the reserved code 11, and with bit 4 cleared. A design that took the code 11 would decode with the low-window bases, and one that skipped the unlock check would move the windows. The bench also writes the register and accesses memory in the same cycle and in the next cycle. This catches a decoder that reads the register's next value instead of its current one.

// File: rtl/reloc_mem_decoder_pkg.sv
package reloc_mem_decoder_pkg;

  typedef enum logic [1:0] {
    LOC_LOW_TOP  = 2'b00,
    LOC_BOTTOM   = 2'b01,
    LOC_HIGH_TOP = 2'b10,
    LOC_RSVD     = 2'b11
  } reloc_e;

  typedef struct packed {
    reloc_e     reloc;
    logic       buf_hi;
    logic       fixed_one;
    logic [3:0] aux;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{reloc: LOC_LOW_TOP, buf_hi: 1'b0,
                                   fixed_one: 1'b1, aux: 4'h0};

endpackage

// File: rtl/mdec_ctrl_reg.sv
module mdec_ctrl_reg
  import reloc_mem_decoder_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       unlock,
  input  logic [7:0] wr_data,
  output ctrl_t      ctrl
);

  ctrl_t wr_view;
  ctrl_t ctrl_nxt;

  assign wr_view = ctrl_t'(wr_data);

  always_comb begin
    ctrl_nxt = ctrl;
    if (wr_en && unlock) begin
      ctrl_nxt.buf_hi = wr_view.buf_hi;
      ctrl_nxt.aux    = wr_view.aux;
      if (wr_view.reloc != LOC_RSVD)
        ctrl_nxt.reloc = wr_view.reloc;
    end
    ctrl_nxt.fixed_one = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl <= CTRL_RESET;
    else     ctrl <= ctrl_nxt;
  end

endmodule

// File: rtl/mdec_window.sv
module mdec_window #(
  parameter int ADDR_W = 24,
  parameter int SPAN_W = 13,
  localparam int TAG_W = ADDR_W - SPAN_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  base_tag,
  output logic              hit,
  output logic [SPAN_W-1:0] offset
);

  assign hit    = (addr[ADDR_W-1:SPAN_W] == base_tag);
  assign offset = addr[SPAN_W-1:0];

endmodule

// File: rtl/reloc_mem_decoder.sv
module reloc_mem_decoder
  import reloc_mem_decoder_pkg::*;
#(
  parameter int              ADDR_W    = 24,
  parameter int              BIG_AW    = 13,
  parameter int              SMALL_AW  = 10,
  parameter int              BUF_AW    = 8,
  parameter logic [ADDR_W-1:0] LT_SMALL = 24'h00DC00,
  parameter logic [ADDR_W-1:0] LT_BIG   = 24'h00E000,
  parameter logic [ADDR_W-1:0] BT_BIG   = 24'h000000,
  parameter logic [ADDR_W-1:0] BT_SMALL = 24'h002000,
  parameter logic [ADDR_W-1:0] HT_SMALL = 24'hFFDC00,
  parameter logic [ADDR_W-1:0] HT_BIG   = 24'hFFE000,
  parameter logic [ADDR_W-1:0] BUF_LO   = 24'h00DB00,
  parameter logic [ADDR_W-1:0] BUF_HI   = 24'hFFDB00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              unlock,
  input  logic [7:0]        wr_data,
  output logic [7:0]        ctrl_q,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              sel_big,
  output logic [BIG_AW-1:0] off_big,
  output logic              sel_small,
  output logic [SMALL_AW-1:0] off_small,
  output logic              sel_buf,
  output logic [BUF_AW-1:0] off_buf
);

  localparam int BIG_TW   = ADDR_W - BIG_AW;
  localparam int SMALL_TW = ADDR_W - SMALL_AW;
  localparam int BUF_TW   = ADDR_W - BUF_AW;

  ctrl_t ctrl;

  mdec_ctrl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .unlock  (unlock),
    .wr_data (wr_data),
    .ctrl    (ctrl)
  );

  assign ctrl_q = ctrl;

  // Window base selection from the current (pre-write) register value
  logic [BIG_TW-1:0]   big_tag;
  logic [SMALL_TW-1:0] small_tag;
  logic [BUF_TW-1:0]   buf_tag;

  always_comb begin
    unique case (ctrl.reloc)
      LOC_BOTTOM: begin
        big_tag   = BT_BIG[ADDR_W-1:BIG_AW];
        small_tag = BT_SMALL[ADDR_W-1:SMALL_AW];
      end
      LOC_HIGH_TOP: begin
        big_tag   = HT_BIG[ADDR_W-1:BIG_AW];
        small_tag = HT_SMALL[ADDR_W-1:SMALL_AW];
      end
      default: begin
        big_tag   = LT_BIG[ADDR_W-1:BIG_AW];
        small_tag = LT_SMALL[ADDR_W-1:SMALL_AW];
      end
    endcase
    buf_tag = ctrl.buf_hi ? BUF_HI[ADDR_W-1:BUF_AW] : BUF_LO[ADDR_W-1:BUF_AW];
  end

  logic                hit_big, hit_small, hit_buf;
  logic [BIG_AW-1:0]   o_big;
  logic [SMALL_AW-1:0] o_small;
  logic [BUF_AW-1:0]   o_buf;

  mdec_window #(.ADDR_W(ADDR_W), .SPAN_W(BIG_AW)) u_win_big (
    .addr(acc_addr), .base_tag(big_tag), .hit(hit_big), .offset(o_big));

  mdec_window #(.ADDR_W(ADDR_W), .SPAN_W(SMALL_AW)) u_win_small (
    .addr(acc_addr), .base_tag(small_tag), .hit(hit_small), .offset(o_small));

  mdec_window #(.ADDR_W(ADDR_W), .SPAN_W(BUF_AW)) u_win_buf (
    .addr(acc_addr), .base_tag(buf_tag), .hit(hit_buf), .offset(o_buf));

  // Priority: buffer, then small SRAM, then big SRAM
  logic pick_buf, pick_small, pick_big;
  assign pick_buf   = acc_valid && hit_buf;
  assign pick_small = acc_valid && hit_small && !hit_buf;
  assign pick_big   = acc_valid && hit_big && !hit_buf && !hit_small;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_big   <= 1'b0;
      sel_small <= 1'b0;
      sel_buf   <= 1'b0;
      off_big   <= '0;
      off_small <= '0;
      off_buf   <= '0;
    end else begin
      sel_big   <= pick_big;
      sel_small <= pick_small;
      sel_buf   <= pick_buf;
      off_big   <= pick_big   ? o_big   : '0;
      off_small <= pick_small ? o_small : '0;
      off_buf   <= pick_buf   ? o_buf   : '0;
    end
  end

endmodule

// File: rtl/reloc_mem_decoder_chk.sv
module reloc_mem_decoder_chk #(
  parameter int ADDR_W   = 24,
  parameter int BIG_AW   = 13,
  parameter int SMALL_AW = 10,
  parameter int BUF_AW   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              unlock,
  input logic [7:0]        wr_data,
  input logic [7:0]        ctrl_q,
  input logic              acc_valid,
  input logic              sel_big,
  input logic [BIG_AW-1:0] off_big,
  input logic              sel_small,
  input logic [SMALL_AW-1:0] off_small,
  input logic              sel_buf,
  input logic [BUF_AW-1:0] off_buf
);

  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_big, sel_small, sel_buf}));

  // R9
  sel_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_big || sel_small || sel_buf) |-> $past(acc_valid));

  // R9
  off_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_big |-> off_big == '0) and (!sel_small |-> off_small == '0)
    and (!sel_buf |-> off_buf == '0));

  // R7
  locked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !unlock) |=> $stable(ctrl_q));

  // R5
  rsvd_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && unlock && wr_data[7:6] == 2'b11) |=> $stable(ctrl_q[7:6]));

  // R8
  fixed_bit_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[4] == 1'b1);

endmodule

bind reloc_mem_decoder reloc_mem_decoder_chk #(
  .ADDR_W(ADDR_W), .BIG_AW(BIG_AW), .SMALL_AW(SMALL_AW), .BUF_AW(BUF_AW)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .unlock(unlock), .wr_data(wr_data),
  .ctrl_q(ctrl_q), .acc_valid(acc_valid),
  .sel_big(sel_big), .off_big(off_big), .sel_small(sel_small),
  .off_small(off_small), .sel_buf(sel_buf), .off_buf(off_buf)
);

// File: tb/reloc_mem_decoder_tb.sv
module reloc_mem_decoder_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, unlock = 1'b0, acc_valid = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [23:0] acc_addr = 24'h0;
  logic [7:0]  ctrl_q;
  logic        sel_big, sel_small, sel_buf;
  logic [12:0] off_big;
  logic [9:0]  off_small;
  logic [7:0]  off_buf;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [7:0] mdl_ctrl;
  logic [2:0] exp_sel;   // {big, small, buf}
  int         exp_ob, exp_os, exp_of;

  always #(CLK_PERIOD/2) clk = ~clk;

  reloc_mem_decoder u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .unlock(unlock), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .sel_big(sel_big), .off_big(off_big), .sel_small(sel_small),
    .off_small(off_small), .sel_buf(sel_buf), .off_buf(off_buf));

  task automatic model_decode(input logic v, input logic [23:0] addr);
    int a, bb, sb, fb;
    a = int'(addr);
    exp_sel = 3'b000; exp_ob = 0; exp_os = 0; exp_of = 0;
    fb = mdl_ctrl[5] ? 'hFFDB00 : 'h00DB00;
    case (mdl_ctrl[7:6])
      2'b01:   begin bb = 'h000000; sb = 'h002000; end
      2'b10:   begin bb = 'hFFE000; sb = 'hFFDC00; end
      default: begin bb = 'h00E000; sb = 'h00DC00; end
    endcase
    if (v) begin
      if (a >= fb && a < fb + 256) begin
        exp_sel = 3'b001; exp_of = a - fb;
      end else if (a >= sb && a < sb + 1024) begin
        exp_sel = 3'b010; exp_os = a - sb;
      end else if (a >= bb && a < bb + 8192) begin
        exp_sel = 3'b100; exp_ob = a - bb;
      end
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check(req, "ctrl_q", int'(ctrl_q), int'(mdl_ctrl));
    check(req, "selects", int'({sel_big, sel_small, sel_buf}), int'(exp_sel));
    check(req, "off_big", int'(off_big), exp_ob);
    check(req, "off_small", int'(off_small), exp_os);
    check(req, "off_buf", int'(off_buf), exp_of);
  endtask

  // one clock: drive at negedge, update model, compare after the next posedge
  task automatic cyc(input logic w, input logic u, input logic [7:0] d,
                     input logic v, input logic [23:0] a, input string req);
    @(negedge clk);
    wr_en = w; unlock = u; wr_data = d; acc_valid = v; acc_addr = a;
    model_decode(v, a);
    if (w && u) begin
      if (d[7:6] != 2'b11) mdl_ctrl[7:6] = d[7:6];
      mdl_ctrl[5]   = d[5];
      mdl_ctrl[3:0] = d[3:0];
    end
    @(posedge clk);
    #1;
    compare(req);
  endtask

  task automatic acc(input logic [23:0] a, input string req);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, a, req);
  endtask

  task automatic sweep(input string req);
    logic [23:0] pts [20] = '{24'h000000, 24'h001FFF, 24'h002000, 24'h0023FF,
      24'h002400, 24'h00DAFF, 24'h00DB00, 24'h00DBFF, 24'h00DC00, 24'h00DFFF,
      24'h00E000, 24'h00FFFF, 24'h010000, 24'hFFDAFF, 24'hFFDB00, 24'hFFDBFF,
      24'hFFDC00, 24'hFFDFFF, 24'hFFE000, 24'hFFFFFF};
    foreach (pts[i]) acc(pts[i], req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mdl_ctrl = 8'h10; exp_sel = 3'b000; exp_ob = 0; exp_os = 0; exp_of = 0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1");                      // reset state while held
    @(negedge clk); rst = 1'b0;
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 24'h0, "R1");

    // R2: default placement, buffer low
    sweep("R2");

    // R7: locked write ignored, then decode unchanged
    cyc(1'b1, 1'b0, 8'h6F, 1'b0, 24'h0, "R7");
    acc(24'h000000, "R7");
    acc(24'h00E000, "R7");

    // R3: bottom placement
    cyc(1'b1, 1'b1, 8'h40, 1'b0, 24'h0, "R3");
    sweep("R3");

    // R4: high placement
    cyc(1'b1, 1'b1, 8'h80, 1'b0, 24'h0, "R4");
    sweep("R4");

    // R5: reserved code keeps placement, other bits written
    cyc(1'b1, 1'b1, 8'hEF, 1'b0, 24'h0, "R5");
    acc(24'hFFE000, "R5");
    acc(24'h00E000, "R5");

    // R6: buffer high location with each placement
    cyc(1'b1, 1'b1, 8'h20, 1'b0, 24'h0, "R6");
    sweep("R6");
    cyc(1'b1, 1'b1, 8'h60, 1'b0, 24'h0, "R6");
    sweep("R6");

    // R8: writing zero to bit 4 still reads 1
    cyc(1'b1, 1'b1, 8'h00, 1'b0, 24'h0, "R8");
    cyc(1'b1, 1'b1, 8'h0A, 1'b0, 24'h0, "R8");

    // R9: invalid accesses inside windows
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 24'h00DB10, "R9");
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 24'h00E123, "R9");

    // R11: write and access in the same cycle, then the next
    cyc(1'b1, 1'b1, 8'h40, 1'b1, 24'h00E004, "R11");
    acc(24'h00E004, "R11");
    cyc(1'b1, 1'b1, 8'h00, 1'b1, 24'h000007, "R11");
    acc(24'h000007, "R11");

    // R10: random mix, buffer priority and single select
    for (int n = 0; n < 3000; n++) begin
      logic [23:0] pick;
      logic [23:0] base [8] = '{24'h000000, 24'h002000, 24'h00DB00, 24'h00DC00,
                                 24'h00E000, 24'hFFDB00, 24'hFFDC00, 24'hFFE000};
      pick = base[$urandom_range(0, 7)] + 24'($urandom_range(0, 9000)) - 24'd200;
      cyc(($urandom_range(0, 15) == 0), $urandom_range(0, 1) == 1,
          8'($urandom), $urandom_range(0, 3) != 0, pick, "R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule